// File: doc/BRIEF.md
# Memory Pattern Recall Game Controller

This block runs a repeat-after-me memory game on a row of LEDs and a group of push buttons. Each round it draws a sequence of LED positions from a 16-bit linear feedback shift register. It plays the sequence one LED at a time, each LED lit for a programmable number of cycles with a short dark pause after it. It then waits for the player to press the matching buttons in the same order. When the round ends, a seven-segment digit shows a pass or a fail letter for a fixed hold time. A new round with fresh positions then starts without further input.

Two difficulty settings are sampled at the start of every round: the number of positions shown and the lit time of each LED. A surrounding controller can leave them fixed or raise them between rounds. The button inputs are single-cycle pulses that are already debounced; each cycle with any bit high counts as one press. There is no streaming data path and therefore no valid/ready handshake. Every pin is a plain control or status signal, and no input can be held off.

The LED count must be a power of two, because a position is taken from the low bits of the shift register.

Top module: `recall_game`

## Requirements
- R1: While reset is asserted, and afterwards until the first button pulse, `led` is all zero and `seg` is blank (7'h00). Any button pulse in the idle state starts the first round.
- R2: The shift register starts at SEED after reset and steps as `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. Element i of a round is the low log2(NUM_LEDS) bits of the state after that round's i-th step. Each round continues from the state the previous round's display left behind.
- R3: During the display, `led` has at most one bit set, and each element's LED stays lit for exactly `on` consecutive cycles.
- R4: After every element, including the last one, `led` stays dark for max(on/4, 1) cycles. After the last pause, `seg` shows a dash (7'h40) while input is awaited.
- R5: The length is taken as 1 when `cfg_len` is 0 and as MAX_LEN when it is larger than MAX_LEN. The lit time is taken as 1 when `cfg_on` is 0. Both values are latched only when a round starts, so changing them during a round has no effect on that round.
- R6: Presses that match the stored positions in order are accepted. In the cycle after the final correct press, `seg` shows the pass letter 7'h73 (segment order g..a in bits 6..0).
- R7: A press that has a wrong bit set, or more than one bit set, ends input at once. In the next cycle `seg` shows the fail letter 7'h71.
- R8: Button pulses during the display and during the result hold are ignored.
- R9: The result stays on `seg` for HOLD_CYCLES cycles. One blank cycle follows with `led` dark, and then the next round's first LED lights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | NUM_LEDS | Debounced button pulses, one bit per LED |
| cfg_len | input | clog2(MAX_LEN+1) | Requested number of positions per round |
| cfg_on | input | PERIOD_W | Requested lit time per LED in cycles |
| led | output | NUM_LEDS | One-hot LED drive during the display |
| seg | output | 7 | Seven-segment pattern, bit 6 = g ... bit 0 = a |

## Verification
The bench sweeps the length from 1 to 16 and several lit times. Lit times of 1 and 3 force the one-cycle minimum pause, which a design needs to tell two equal neighbouring positions apart; without it, a doubled position would merge into one long pulse. Wrong presses are placed at the first, middle and last positions, and one is a two-button press. A design that kept listening after a wrong press, or that accepted any press containing the right bit, would show a dash or a pass letter instead of the fail letter. Zero and oversized settings, settings changed in mid-round, button pulses during the display and the hold, and a reset in mid-display followed by a restart from the seed all catch designs that clamp wrongly, latch at the wrong time or fail to restart the sequence.

// File: rtl/recall_pkg.sv
package recall_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHOW_ON,
    ST_SHOW_GAP,
    ST_WAIT_INPUT,
    ST_RESULT,
    ST_NEXT
  } game_state_t;

  // segment bits are {g,f,e,d,c,b,a}
  localparam logic [6:0] SEG_BLANK = 7'h00;
  localparam logic [6:0] SEG_DASH  = 7'h40;
  localparam logic [6:0] SEG_PASS  = 7'h73;
  localparam logic [6:0] SEG_FAIL  = 7'h71;

  // maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [15:0] lfsr_advance(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/recall_seq.sv
module recall_seq
  import recall_pkg::*;
#(
  parameter int          IDX_W = 2,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap,
  input  logic             step_gen,
  input  logic             step_chk,
  output logic [IDX_W-1:0] show_pos,
  output logic [IDX_W-1:0] want_pos
);

  logic [15:0] gen_q;
  logic [15:0] chk_q;
  logic [15:0] chk_nx;

  assign chk_nx   = lfsr_advance(chk_q);
  assign show_pos = gen_q[IDX_W-1:0];
  assign want_pos = chk_nx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= SEED;
      chk_q <= SEED;
    end else begin
      if (step_gen) gen_q <= lfsr_advance(gen_q);
      if (snap)          chk_q <= gen_q;
      else if (step_chk) chk_q <= chk_nx;
    end
  end

  // R2: neither register may fall into the all-zero lock-up state
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q != 16'h0) && (chk_q != 16'h0));

endmodule

// File: rtl/recall_timer.sv
module recall_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R3: without a load the count never rises
  a_r3_timer_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/recall_face.sv
module recall_face
  import recall_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int IDX_W    = 2
) (
  input  game_state_t      state,
  input  logic             pass,
  input  logic [IDX_W-1:0] show_pos,
  output logic [NUM_LEDS-1:0] led,
  output logic [6:0]       seg
);

  always_comb begin
    led = '0;
    if (state == ST_SHOW_ON) led[show_pos] = 1'b1;
  end

  always_comb begin
    unique case (state)
      ST_WAIT_INPUT: seg = SEG_DASH;
      ST_RESULT:     seg = pass ? SEG_PASS : SEG_FAIL;
      default:       seg = SEG_BLANK;
    endcase
  end

endmodule

// File: rtl/recall_game.sv
module recall_game
  import recall_pkg::*;
#(
  parameter int          NUM_LEDS    = 4,
  parameter int          MAX_LEN     = 16,
  parameter int          PERIOD_W    = 16,
  parameter int          HOLD_CYCLES = 40000,
  parameter logic [15:0] SEED        = 16'hACE1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LEDS-1:0]          btn,
  input  logic [$clog2(MAX_LEN+1)-1:0] cfg_len,
  input  logic [PERIOD_W-1:0]          cfg_on,
  output logic [NUM_LEDS-1:0]          led,
  output logic [6:0]                   seg
);

  localparam int IDX_W  = $clog2(NUM_LEDS);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int TMR_W  = (PERIOD_W > HOLD_W) ? PERIOD_W : HOLD_W;

  game_state_t state, state_n;

  logic [LEN_W-1:0]    len_r, shown_r, cnt_r, len_in;
  logic [PERIOD_W-1:0] on_r, gap_r, on_in, gap_in;
  logic                pass_r;

  logic                snap, step_gen, step_chk, begin_rnd;
  logic                t_load, t_done;
  logic [TMR_W-1:0]    t_val;
  logic [IDX_W-1:0]    show_pos, want_pos;
  logic [NUM_LEDS-1:0] want_oh;
  logic                pressed, hit;

  // round settings, clamped before they are latched
  always_comb begin
    if (cfg_len == '0)                      len_in = LEN_W'(1);
    else if (cfg_len > LEN_W'(MAX_LEN))     len_in = LEN_W'(MAX_LEN);
    else                                    len_in = cfg_len;
    on_in  = (cfg_on == '0) ? PERIOD_W'(1) : cfg_on;
    gap_in = ((on_in >> 2) == '0) ? PERIOD_W'(1) : (on_in >> 2);
  end

  assign want_oh = {{(NUM_LEDS-1){1'b0}}, 1'b1} << want_pos;
  assign pressed = |btn;
  assign hit     = (btn == want_oh);

  always_comb begin
    state_n   = state;
    snap      = 1'b0;
    step_gen  = 1'b0;
    step_chk  = 1'b0;
    begin_rnd = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    unique case (state)
      ST_IDLE: if (pressed) begin_rnd = 1'b1;
      ST_SHOW_ON: if (t_done) begin
        state_n = ST_SHOW_GAP;
        t_load  = 1'b1;
        t_val   = TMR_W'(gap_r - 1'b1);
      end
      ST_SHOW_GAP: if (t_done) begin
        if (shown_r == len_r) begin
          state_n = ST_WAIT_INPUT;
        end else begin
          state_n  = ST_SHOW_ON;
          step_gen = 1'b1;
          t_load   = 1'b1;
          t_val    = TMR_W'(on_r - 1'b1);
        end
      end
      ST_WAIT_INPUT: if (pressed) begin
        if (hit) step_chk = 1'b1;
        if (!hit || ((cnt_r + 1'b1) == len_r)) begin
          state_n = ST_RESULT;
          t_load  = 1'b1;
          t_val   = TMR_W'(HOLD_CYCLES - 1);
        end
      end
      ST_RESULT: if (t_done) state_n = ST_NEXT;
      ST_NEXT:   begin_rnd = 1'b1;
      default:   state_n = ST_IDLE;
    endcase
    if (begin_rnd) begin
      state_n  = ST_SHOW_ON;
      snap     = 1'b1;
      step_gen = 1'b1;
      t_load   = 1'b1;
      t_val    = TMR_W'(on_in - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      len_r   <= LEN_W'(1);
      on_r    <= PERIOD_W'(1);
      gap_r   <= PERIOD_W'(1);
      shown_r <= '0;
      cnt_r   <= '0;
      pass_r  <= 1'b0;
    end else begin
      state <= state_n;
      if (begin_rnd) begin
        len_r   <= len_in;
        on_r    <= on_in;
        gap_r   <= gap_in;
        shown_r <= LEN_W'(1);
        cnt_r   <= '0;
      end else if (step_gen) begin
        shown_r <= shown_r + 1'b1;
      end
      if (step_chk) cnt_r <= cnt_r + 1'b1;
      if (state == ST_WAIT_INPUT && state_n == ST_RESULT) pass_r <= hit;
    end
  end

  recall_seq #(.IDX_W(IDX_W), .SEED(SEED)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .snap     (snap),
    .step_gen (step_gen),
    .step_chk (step_chk),
    .show_pos (show_pos),
    .want_pos (want_pos)
  );

  recall_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  recall_face #(.NUM_LEDS(NUM_LEDS), .IDX_W(IDX_W)) u_face (
    .state    (state),
    .pass     (pass_r),
    .show_pos (show_pos),
    .led      (led),
    .seg      (seg)
  );

  // R3: at most one LED lit
  a_r3_led_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led));

  // R7: a mismatching press ends the round with a fail
  a_r7_wrong_press_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_INPUT && pressed && !hit) |=> (state == ST_RESULT && !pass_r));

  // R5: settings only change when a round begins
  a_r5_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_NEXT) |=> ($stable(len_r) && $stable(on_r)));

  // R8: the result hold is not disturbed by buttons
  a_r8_result_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESULT && !t_done) |=> (state == ST_RESULT && $stable(pass_r)));

  // R9: the blank cycle is followed by a new display
  a_r9_next_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT) |=> (state == ST_SHOW_ON));

  // R6: accepted presses never run past the round length
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_INPUT) |-> (cnt_r < len_r));

endmodule

// File: tb/recall_game_tb.sv
module recall_game_tb;

  localparam int          HOLD = 6;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int          NR   = 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn = '0;
  logic [4:0] cfg_len = 5'd1;
  logic [15:0] cfg_on = 16'd1;
  logic [3:0] led;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;
  logic [15:0] model;

  int rl[NR];
  int ro[NR];
  int rf[NR];
  bit rm[NR];
  bit ri[NR];
  int on_tab[5] = '{1, 3, 4, 8, 9};

  always #4 clk = ~clk;

  recall_game #(.NUM_LEDS(4), .MAX_LEN(16), .PERIOD_W(16),
                .HOLD_CYCLES(HOLD), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn(btn),
    .cfg_len(cfg_len), .cfg_on(cfg_on), .led(led), .seg(seg)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [3:0] oh(input int p);
    return 4'b0001 << p;
  endfunction

  task automatic tick();
    @(negedge clk);
    btn = '0;
  endtask

  task automatic run_round(input int len, input int on, input int fail_at,
                           input bit multi, input bit inject,
                           input int nlen, input int non);
    int elen, eon, gap, w;
    int pat[16];
    bit failed;
    logic [6:0] expseg;
    elen = (len == 0) ? 1 : ((len > 16) ? 16 : len);
    eon  = (on == 0) ? 1 : on;
    gap  = (eon / 4 == 0) ? 1 : eon / 4;
    w = 0;
    while (led == 4'h0 && w < 64) begin tick(); w++; end
    check(led != 4'h0, "R9 display begins", led, 1);
    for (int i = 0; i < elen; i++) begin
      model = nxt(model);
      pat[i] = int'(model[1:0]);
      if (i > 0) tick();
      check(led == oh(pat[i]), "R2 shown position", led, oh(pat[i]));
      if (i == 0) begin cfg_len = 5'd7; cfg_on = 16'd2; end // R5 mid-round change
      for (int j = 1; j < eon; j++) begin
        tick();
        check(led == oh(pat[i]), "R3 lit period", led, oh(pat[i]));
      end
      for (int g = 0; g < gap; g++) begin
        tick();
        check(led == 4'h0 && seg == 7'h00,
              (inject && i == 0) ? "R8 press during display ignored" : "R4 dark pause",
              led, 0);
        if (g == 0 && i == 0 && inject) btn = 4'hF;
      end
    end
    tick();
    check(seg == 7'h40 && led == 4'h0, "R5 length reached, input phase", seg, 7'h40);
    failed = 1'b0;
    for (int k = 0; k < elen; k++) begin
      if (k == fail_at)
        btn = multi ? (oh(pat[k]) | oh((pat[k] + 1) % 4)) : oh((pat[k] + 1) % 4);
      else
        btn = oh(pat[k]);
      tick();
      if (k == fail_at) begin
        check(seg == 7'h71, "R7 wrong press fails at once", seg, 7'h71);
        failed = 1'b1;
        break;
      end else if (k == elen - 1) begin
        check(seg == 7'h73, "R6 full entry passes", seg, 7'h73);
      end else begin
        check(seg == 7'h40, "R6 partial entry keeps waiting", seg, 7'h40);
      end
    end
    expseg = failed ? 7'h71 : 7'h73;
    cfg_len = 5'(nlen);
    cfg_on  = 16'(non);
    if (inject) btn = oh(pat[0]);
    for (int h = 1; h < HOLD; h++) begin
      tick();
      check(seg == expseg, inject ? "R8 press during result ignored" : "R9 result hold",
            seg, expseg);
    end
    tick();
    check(seg == 7'h00 && led == 4'h0, "R9 blank cycle after hold", seg, 0);
    tick();
    check(led != 4'h0, "R9 next round lights", led, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) begin
      rl[r] = r + 1;
      ro[r] = on_tab[r % 5];
      rf[r] = (r % 3 == 2) ? ((r / 3) % (r + 1)) : -1;
      rm[r] = (r == 5);
      ri[r] = (r % 4 == 1);
    end
    rl[16] = 0;  ro[16] = 0; rf[16] = -1; rm[16] = 0; ri[16] = 0;
    rl[17] = 20; ro[17] = 2; rf[17] = 15; rm[17] = 0; ri[17] = 0;
    rl[18] = 31; ro[18] = 5; rf[18] = -1; rm[18] = 0; ri[18] = 1;
    rl[19] = 2;  ro[19] = 1; rf[19] = 0;  rm[19] = 1; ri[19] = 0;
    rl[20] = 16; ro[20] = 9; rf[20] = -1; rm[20] = 0; ri[20] = 0;

    model = SEED;
    repeat (3) tick();
    check(led == 4'h0 && seg == 7'h00, "R1 outputs in reset", led, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 10; c++) begin
      tick();
      check(led == 4'h0 && seg == 7'h00, "R1 idle until press", led, 0);
    end
    cfg_len = 5'(rl[0]);
    cfg_on  = 16'(ro[0]);
    btn = 4'b0100;
    tick();
    for (int r = 0; r < NR; r++) begin
      run_round(rl[r], ro[r], rf[r], rm[r], ri[r],
                (r + 1 < NR) ? rl[r + 1] : 3, (r + 1 < NR) ? ro[r + 1] : 4);
    end

    rst_n = 1'b0;
    tick();
    tick();
    check(led == 4'h0 && seg == 7'h00, "R1 reset during display", led, 0);
    rst_n = 1'b1;
    model = SEED;
    tick();
    check(led == 4'h0 && seg == 7'h00, "R1 idle after reset", led, 0);
    cfg_len = 5'd4;
    cfg_on  = 16'd4;
    btn = 4'b0001;
    tick();
    run_round(4, 4, -1, 1'b0, 1'b1, 4, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule